// File: doc/BRIEF.md
# DMA Channel Completion and Link Control

This block keeps the per-channel control and status state of a sixteen-channel DMA engine. Each channel has a start request, a done flag, a completion-link enable, a scatter-gather enable, a four-bit link target and a major iteration counter. Software reaches this state through a simple register port. Each cycle the port takes at most one write and serves one combinational read.

The engine reports two kinds of per-channel event. One is a decrement of the iteration counter; the other is that a channel has become active. When a decrement takes a counter from one to zero, the channel's done flag is set. If the channel's link enable is set, the start request of its link target is raised at the same clock edge. That target can be any channel, the channel itself included. Activation clears both the start request and the done flag. While done is set, writes to the two enable bits are locked out.

Top module: `dmalink_top`

## Requirements
- R1: Synchronous active-high reset clears every control bit, link target and counter of every channel, so `start_o`, `done_o` and every read return 0.
- R2: Control word layout, read and written with `rd_sel`/`wr_sel` = 0: bit 0 start, bit 1 link enable, bit 2 scatter-gather enable, bit 3 done, bits 7:4 link target channel. A write updates start and the link target unconditionally.
- R3: With `wr_sel`/`rd_sel` = 1 the word is the channel's iteration counter. Each decrement event lowers it by one. A decrement while it is already zero changes nothing.
- R4: A decrement event on a channel whose counter is 1 sets that channel's done flag at the same edge that the counter reaches zero.
- R5: At that completion edge, if the channel's link enable is 1, the start bit of the channel named by its link target is set.
- R6: At that completion edge, if link enable is 0, no start bit is set.
- R7: A control write with bit 3 = 0 clears done. A write with bit 3 = 1 leaves done unchanged.
- R8: An activation event on a channel clears its start bit and its done flag at the next edge.
- R9: While done is 1, a control write leaves link enable and scatter-gather enable unchanged. The lock uses the done value held before the write, so a write that clears done cannot also change the enables.
- R10: A link set of a start bit overrides a same-cycle software write of 0 and a same-cycle activation of that channel.
- R11: A channel whose link target is itself sets its own start bit on completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 iteration counter |
| wr_ch | input | 4 | Channel being written |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 control word, 1 iteration counter |
| rd_ch | input | 4 | Channel being read |
| rd_data | output | 8 | Combinational read data |
| dec_evt | input | 16 | Per-channel iteration decrement events |
| act_evt | input | 16 | Per-channel activation events |
| start_o | output | 16 | Per-channel start requests |
| done_o | output | 16 | Per-channel done flags |

## Verification
A wrong counter or a missed zero-crossing shows up one edge after the last decrement. Either `done_o` stays low, or the start bit of the link target fails to rise. A wrong link target or a dropped link enable raises the wrong bit of `start_o` at that same edge. A lock that fails to hold shows as a changed control word on the very next read. A wrong priority between link, activation and software write leaves the target's start bit low one edge after the collision.

// File: rtl/dmalink_pkg.sv
package dmalink_pkg;
    localparam int NUM_CH = 16;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int REG_W  = 8;

    typedef struct packed {
        logic [CH_W-1:0] link_ch;
        logic            done;
        logic            sg_en;
        logic            link_en;
        logic            start;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [REG_W-1:0] w);
        return ctrl_t'(w);
    endfunction
endpackage

// File: rtl/dmalink_iter_cnt.sv
module dmalink_iter_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             hit_zero
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign hit_zero = dec && (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - ONE;
    end
endmodule

// File: rtl/dmalink_linkmap.sv
module dmalink_linkmap
    import dmalink_pkg::*;
(
    input  logic [NUM_CH-1:0]           hit,
    input  logic [NUM_CH-1:0]           link_en,
    input  logic [NUM_CH-1:0][CH_W-1:0] link_ch,
    output logic [NUM_CH-1:0]           set_vec
);
    always_comb begin
        set_vec = '0;
        for (int s = 0; s < NUM_CH; s++) begin
            if (hit[s] && link_en[s])
                set_vec[link_ch[s]] = 1'b1;
        end
    end
endmodule

// File: rtl/dmalink_chan.sv
module dmalink_chan
    import dmalink_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic [REG_W-1:0] wr_data,
    input  logic             act,
    input  logic             hit,
    input  logic             link_set,
    output ctrl_t            ctrl
);
    ctrl_t wr_w;
    ctrl_t nxt;

    assign wr_w = ctrl_from_word(wr_data);

    always_comb begin
        nxt = ctrl;
        if (wr_ctrl) begin
            nxt.link_ch = wr_w.link_ch;
            nxt.start   = wr_w.start;
            if (!ctrl.done) begin
                nxt.link_en = wr_w.link_en;
                nxt.sg_en   = wr_w.sg_en;
            end
            if (!wr_w.done)
                nxt.done = 1'b0;
        end
        if (act) begin
            nxt.start = 1'b0;
            nxt.done  = 1'b0;
        end
        if (hit)
            nxt.done = 1'b1;
        if (link_set)
            nxt.start = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else
            ctrl <= nxt;
    end
endmodule

// File: rtl/dmalink_top.sv
module dmalink_top
    import dmalink_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_sel,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [REG_W-1:0]  rd_data,
    input  logic [NUM_CH-1:0] dec_evt,
    input  logic [NUM_CH-1:0] act_evt,
    output logic [NUM_CH-1:0] start_o,
    output logic [NUM_CH-1:0] done_o
);
    ctrl_t [NUM_CH-1:0]            ctrl_q;
    logic  [NUM_CH-1:0][CNT_W-1:0] cnt_q;
    logic  [NUM_CH-1:0]            hit_v;
    logic  [NUM_CH-1:0]            link_set_v;
    logic  [NUM_CH-1:0]            link_en_v;
    logic  [NUM_CH-1:0][CH_W-1:0]  link_ch_v;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel_c;
        assign sel_c = wr_en && (wr_ch == CH_W'(c));

        dmalink_iter_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .load     (sel_c && wr_sel),
            .load_val (wr_data[CNT_W-1:0]),
            .dec      (dec_evt[c]),
            .cnt      (cnt_q[c]),
            .hit_zero (hit_v[c])
        );

        dmalink_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_ctrl  (sel_c && !wr_sel),
            .wr_data  (wr_data),
            .act      (act_evt[c]),
            .hit      (hit_v[c]),
            .link_set (link_set_v[c]),
            .ctrl     (ctrl_q[c])
        );

        assign start_o[c]   = ctrl_q[c].start;
        assign done_o[c]    = ctrl_q[c].done;
        assign link_en_v[c] = ctrl_q[c].link_en;
        assign link_ch_v[c] = ctrl_q[c].link_ch;
    end

    dmalink_linkmap u_linkmap (
        .hit     (hit_v),
        .link_en (link_en_v),
        .link_ch (link_ch_v),
        .set_vec (link_set_v)
    );

    always_comb begin
        if (rd_sel)
            rd_data = REG_W'(cnt_q[rd_ch]);
        else
            rd_data = ctrl_q[rd_ch];
    end
endmodule

// File: rtl/dmalink_checker.sv
module dmalink_checker
    import dmalink_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [CH_W-1:0]   wr_ch,
    input logic [NUM_CH-1:0] act_evt,
    input logic [NUM_CH-1:0] hit_v,
    input logic [NUM_CH-1:0] link_set_v,
    input logic [NUM_CH-1:0] link_en_v,
    input logic [NUM_CH-1:0] start_o,
    input logic [NUM_CH-1:0] done_o
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (start_o == '0 && done_o == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_done_on_zero_R4: assert property (@(posedge clk) disable iff (rst)
            hit_v[c] |=> done_o[c]);

        assert_link_sets_start_R5: assert property (@(posedge clk) disable iff (rst)
            link_set_v[c] |=> start_o[c]);

        assert_act_clears_start_R8: assert property (@(posedge clk) disable iff (rst)
            (act_evt[c] && !link_set_v[c]) |=> !start_o[c]);

        assert_act_clears_done_R8: assert property (@(posedge clk) disable iff (rst)
            (act_evt[c] && !hit_v[c]) |=> !done_o[c]);

        assert_enable_locked_R9: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !wr_sel && wr_ch == CH_W'(c) && done_o[c]) |=> $stable(link_en_v[c]));
    end
endmodule

bind dmalink_top dmalink_checker u_checker (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_ch      (wr_ch),
    .act_evt    (act_evt),
    .hit_v      (hit_v),
    .link_set_v (link_set_v),
    .link_en_v  (link_en_v),
    .start_o    (start_o),
    .done_o     (done_o)
);

// File: tb/dmalink_top_tb.sv
module dmalink_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [3:0]  wr_ch = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [3:0]  rd_ch = '0;
    logic [7:0]  rd_data;
    logic [15:0] dec_evt = '0;
    logic [15:0] act_evt = '0;
    logic [15:0] start_o;
    logic [15:0] done_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dmalink_top u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_ch(wr_ch),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_ch(rd_ch), .rd_data(rd_data),
        .dec_evt(dec_evt), .act_evt(act_evt), .start_o(start_o), .done_o(done_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read(input logic sel, input logic [3:0] ch, output logic [7:0] d);
        rd_sel = sel;
        rd_ch  = ch;
        #1;
        d = rd_data;
    endtask

    task automatic write(input logic sel, input logic [3:0] ch, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_ch = ch; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] dec, input logic [15:0] act);
        @(negedge clk);
        dec_evt = dec; act_evt = act;
        @(negedge clk);
        dec_evt = '0; act_evt = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 start", start_o, 16'h0);
        check("R1 done", done_o, 16'h0);
        read(1'b0, 4'd5, d); check("R1 ctrl", {8'h0, d}, 16'h0);
        read(1'b1, 4'd5, d); check("R1 cnt", {8'h0, d}, 16'h0);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        write(1'b0, 4'd3, 8'hA6);
        read(1'b0, 4'd3, d); check("R2 ctrl layout", {8'h0, d}, 16'h00A6);
        write(1'b0, 4'd3, 8'hA1);
        read(1'b0, 4'd3, d); check("R2 start write", {8'h0, d}, 16'h00A1);
        check("R2 start_o", start_o, 16'h0008);
        write(1'b0, 4'd3, 8'h00);
        write(1'b1, 4'd3, 8'd5);
        read(1'b1, 4'd3, d); check("R3 cnt load", {8'h0, d}, 16'd5);
    endtask

    task automatic t_count();
        logic [7:0] d;
        write(1'b1, 4'd2, 8'd3);
        pulse(16'h0004, 16'h0);
        pulse(16'h0004, 16'h0);
        read(1'b1, 4'd2, d); check("R3 decrement", {8'h0, d}, 16'd1);
        check("R4 not yet done", done_o, 16'h0);
        pulse(16'h0004, 16'h0);
        check("R4 done set", done_o, 16'h0004);
        check("R6 no link", start_o, 16'h0);
        pulse(16'h0004, 16'h0);
        read(1'b1, 4'd2, d); check("R3 dec at zero", {8'h0, d}, 16'd0);
        write(1'b0, 4'd2, 8'h00);
    endtask

    task automatic t_link_lock();
        logic [7:0] d;
        write(1'b0, 4'd4, 8'h92);
        write(1'b1, 4'd4, 8'd1);
        pulse(16'h0010, 16'h0);
        check("R5 link start", start_o, 16'h0200);
        check("R5 done", done_o, 16'h0010);
        write(1'b0, 4'd4, 8'h98);
        read(1'b0, 4'd4, d); check("R7 R9 locked", {8'h0, d}, 16'h009A);
        write(1'b0, 4'd4, 8'h94);
        read(1'b0, 4'd4, d); check("R7 R9 clear same write", {8'h0, d}, 16'h0092);
        write(1'b0, 4'd4, 8'h94);
        read(1'b0, 4'd4, d); check("R9 unlocked", {8'h0, d}, 16'h0094);
    endtask

    task automatic t_active();
        write(1'b0, 4'd6, 8'h00);
        write(1'b1, 4'd6, 8'd1);
        pulse(16'h0040, 16'h0);
        check("R4 ch6 done", done_o, 16'h0040);
        pulse(16'h0, 16'h0240);
        check("R8 start clear", start_o, 16'h0);
        check("R8 done clear", done_o, 16'h0);
    endtask

    task automatic t_priority();
        write(1'b0, 4'd7, 8'hB2);
        write(1'b1, 4'd7, 8'd1);
        @(negedge clk);
        dec_evt = 16'h0080; act_evt = 16'h0800;
        wr_en = 1'b1; wr_sel = 1'b0; wr_ch = 4'd11; wr_data = 8'h00;
        @(negedge clk);
        dec_evt = '0; act_evt = '0; wr_en = 1'b0;
        check("R10 link wins", start_o, 16'h0800);
        pulse(16'h0, 16'h0880);
    endtask

    task automatic t_self();
        write(1'b0, 4'd12, 8'hC2);
        write(1'b1, 4'd12, 8'd1);
        pulse(16'h1000, 16'h0);
        check("R11 self start", start_o, 16'h1000);
        check("R11 self done", done_o, 16'h1000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_count();
        t_link_lock();
        t_active();
        t_priority();
        t_self();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule